// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides, for one commit slot, which hardware thread of a multithreaded core may retire the instruction at the head of its reorder buffer. Each thread reports a status code, a head-ready flag, a buffer-empty flag and the sequence number of its head instruction. A two-bit policy input picks the arbitration rule, and a request strobe asks for one decision. The answer comes back in the same cycle as a valid bit and a thread index.

Under the rotating policy the block holds an ordered list of thread indices. A thread that wins moves to the back of that list, so the other threads move up. Under the age-based policy, and under the aggressive policy that behaves the same way, the qualifying thread with the oldest head instruction wins. When the block is built for a single thread, it looks only at that thread's status. The commit stage requests once per retirement slot, and the ordered list advances only on a request that produces a grant.

Top module: `smt_commit_picker`

## Requirements
- R1: After reset the rotating list holds the thread indices in ascending order, so the first rotating grant with every thread qualifying goes to thread 0.
- R2: A thread is eligible only when its status code is 0 (idle), 1 (running) or 4 (waiting on a fetch-side trap). Codes 2, 3 and 5 to 7 exclude it. Thread i's status is at bits [3i+2:3i].
- R3: Under policy code 1 (rotating), the list is scanned from its front. The first thread that is eligible, has head_ready high and has rob_empty low is granted.
- R4: A thread granted under the rotating policy moves to the back of the list. The threads behind it each move forward one place.
- R5: The list changes only on a cycle where pick_req is high, the policy is rotating and a grant is made. Requests under other policies, and cycles without a request, leave the list as it was.
- R6: Under policy code 2 (oldest ready), among the eligible threads with a ready head and a non-empty buffer, the thread whose head sequence number (bits [SEQ_W*i+SEQ_W-1:SEQ_W*i]) is smallest is granted. The comparison is unsigned.
- R7: Under the age-based policies, equal smallest sequence numbers are resolved toward the lower thread index.
- R8: Policy code 0 (aggressive) grants exactly as policy code 2 does.
- R9: When no thread qualifies, pick_valid is low and pick_tid is 0.
- R10: With NUM_THREADS = 1, the thread is granted whenever pick_req is high and its status is eligible. Head readiness, buffer emptiness, sequence number and policy are not looked at.
- R11: When pick_req is low, pick_valid is low.
- R12: With more than one thread, policy code 3 is reserved and grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_status | input | 3*NUM_THREADS | Per-thread status code |
| head_ready | input | NUM_THREADS | Per-thread head instruction ready to retire |
| rob_empty | input | NUM_THREADS | Per-thread reorder buffer empty |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| policy | input | 2 | 0 aggressive, 1 rotating, 2 oldest ready, 3 reserved |
| pick_req | input | 1 | Request one decision this cycle |
| pick_valid | output | 1 | A thread was granted |
| pick_tid | output | max(1,clog2(NUM_THREADS)) | Index of the granted thread |

## Verification
The bench first targets list rotation. It interleaves rotating requests with idle cycles and with requests under other policies. A design that advanced the list on every request, or that rotated without a grant, would grant out of order afterwards. Ties in sequence number, and threads that are ready but ineligible, or eligible but with an empty buffer, are driven on purpose. A wrong tie rule picks the higher index, and a missing qualifier grants a thread that must not retire. A second instance built with one thread checks that head readiness is ignored there; a design that kept the multi-thread qualification would withhold grants.

// File: rtl/smt_pick_pkg.sv
package smt_pick_pkg;

   localparam int STATE_W = 3;
   localparam int POL_W   = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE            = 3'd0,
      ST_RUNNING         = 3'd1,
      ST_SQUASHING       = 3'd2,
      ST_TRAP_WAIT       = 3'd3,
      ST_FETCH_TRAP_WAIT = 3'd4
   } thr_state_e;

   localparam logic [POL_W-1:0] POL_AGGRESSIVE = 2'd0;
   localparam logic [POL_W-1:0] POL_ROTATE     = 2'd1;
   localparam logic [POL_W-1:0] POL_OLDEST     = 2'd2;

   function automatic logic state_eligible(input logic [STATE_W-1:0] s);
      return (s == ST_IDLE) || (s == ST_RUNNING) || (s == ST_FETCH_TRAP_WAIT);
   endfunction

endpackage

// File: rtl/smt_pick_rr_order.sv
module smt_pick_rr_order #(
   parameter int NT    = 4,
   parameter int TID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NT-1:0]    qual,
   input  logic             advance,
   output logic             grant_valid,
   output logic [TID_W-1:0] grant_tid
);

   logic [TID_W-1:0] order_q [NT];
   logic [TID_W-1:0] order_d [NT];
   logic [TID_W-1:0] hit_pos;

   // scan the list from its front
   always_comb begin
      grant_valid = 1'b0;
      grant_tid   = '0;
      hit_pos     = '0;
      for (int p = 0; p < NT; p++) begin
         if (!grant_valid && qual[order_q[p]]) begin
            grant_valid = 1'b1;
            grant_tid   = order_q[p];
            hit_pos     = TID_W'(p);
         end
      end
   end

   // remove the winner and append it at the tail
   always_comb begin
      for (int i = 0; i < NT; i++) begin
         if (i < int'(hit_pos))
            order_d[i] = order_q[i];
         else if (i < NT-1)
            order_d[i] = order_q[(i+1) % NT];
         else
            order_d[i] = order_q[hit_pos];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) order_q[i] <= TID_W'(i);
      end else if (advance && grant_valid) begin
         for (int i = 0; i < NT; i++) order_q[i] <= order_d[i];
      end
   end

endmodule

// File: rtl/smt_pick_oldest.sv
module smt_pick_oldest #(
   parameter int NT    = 4,
   parameter int SEQ_W = 16,
   parameter int TID_W = 2
) (
   input  logic [NT-1:0]       qual,
   input  logic [NT*SEQ_W-1:0] seq,
   output logic                grant_valid,
   output logic [TID_W-1:0]    grant_tid
);

   logic [SEQ_W-1:0] best_seq;

   // strict compare keeps the lower index on equal numbers
   always_comb begin
      grant_valid = 1'b0;
      grant_tid   = '0;
      best_seq    = '0;
      for (int i = 0; i < NT; i++) begin
         if (qual[i] && (!grant_valid || (seq[i*SEQ_W +: SEQ_W] < best_seq))) begin
            grant_valid = 1'b1;
            grant_tid   = TID_W'(i);
            best_seq    = seq[i*SEQ_W +: SEQ_W];
         end
      end
   end

endmodule

// File: rtl/smt_commit_picker.sv
module smt_commit_picker
   import smt_pick_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 16,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [STATE_W*NUM_THREADS-1:0] thr_status,
   input  logic [NUM_THREADS-1:0]       head_ready,
   input  logic [NUM_THREADS-1:0]       rob_empty,
   input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
   input  logic [POL_W-1:0]             policy,
   input  logic                         pick_req,
   output logic                         pick_valid,
   output logic [TID_W-1:0]             pick_tid
);

   if (NUM_THREADS < 1) begin : g_bad_nt
      $error("NUM_THREADS must be at least 1");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("SEQ_W must be at least 1");
   end

   if (NUM_THREADS == 1) begin : g_single
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, head_ready, rob_empty, head_seq, policy};
      assign pick_valid = pick_req && state_eligible(thr_status[STATE_W-1:0]);
      assign pick_tid   = '0;
   end else begin : g_multi
      logic [NUM_THREADS-1:0] qual;
      logic                   rr_valid, old_valid;
      logic [TID_W-1:0]       rr_tid, old_tid;
      logic                   rr_advance;

      always_comb begin
         for (int i = 0; i < NUM_THREADS; i++) begin
            qual[i] = state_eligible(thr_status[i*STATE_W +: STATE_W])
                      && head_ready[i] && !rob_empty[i];
         end
      end

      assign rr_advance = pick_req && (policy == POL_ROTATE);

      smt_pick_rr_order #(
         .NT    (NUM_THREADS),
         .TID_W (TID_W)
      ) rr_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .qual        (qual),
         .advance     (rr_advance),
         .grant_valid (rr_valid),
         .grant_tid   (rr_tid)
      );

      smt_pick_oldest #(
         .NT    (NUM_THREADS),
         .SEQ_W (SEQ_W),
         .TID_W (TID_W)
      ) old_i (
         .qual        (qual),
         .seq         (head_seq),
         .grant_valid (old_valid),
         .grant_tid   (old_tid)
      );

      always_comb begin
         pick_valid = 1'b0;
         pick_tid   = '0;
         if (pick_req) begin
            case (policy)
               POL_ROTATE: begin
                  pick_valid = rr_valid;
                  pick_tid   = rr_valid ? rr_tid : '0;
               end
               POL_AGGRESSIVE, POL_OLDEST: begin
                  pick_valid = old_valid;
                  pick_tid   = old_valid ? old_tid : '0;
               end
               default: begin
                  pick_valid = 1'b0;
                  pick_tid   = '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/smt_commit_picker_chk.sv
module smt_commit_picker_chk
   import smt_pick_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 16,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [STATE_W*NUM_THREADS-1:0] thr_status,
   input logic [NUM_THREADS-1:0]         head_ready,
   input logic [NUM_THREADS-1:0]         rob_empty,
   input logic [SEQ_W*NUM_THREADS-1:0]   head_seq,
   input logic [POL_W-1:0]               policy,
   input logic                           pick_req,
   input logic                           pick_valid,
   input logic [TID_W-1:0]               pick_tid
);

   logic             sel_elig, sel_qual, older_seen, tie_lower;
   logic [SEQ_W-1:0] sel_seq;

   always_comb begin
      sel_elig = 1'b0;
      sel_qual = 1'b0;
      sel_seq  = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (TID_W'(i) == pick_tid) begin
            sel_elig = state_eligible(thr_status[i*STATE_W +: STATE_W]);
            sel_qual = head_ready[i] && !rob_empty[i];
            sel_seq  = head_seq[i*SEQ_W +: SEQ_W];
         end
      end
      older_seen = 1'b0;
      tie_lower  = 1'b0;
      for (int j = 0; j < NUM_THREADS; j++) begin
         if (state_eligible(thr_status[j*STATE_W +: STATE_W]) && head_ready[j] && !rob_empty[j]) begin
            if (head_seq[j*SEQ_W +: SEQ_W] < sel_seq) older_seen = 1'b1;
            if ((head_seq[j*SEQ_W +: SEQ_W] == sel_seq) && (TID_W'(j) < pick_tid)) tie_lower = 1'b1;
         end
      end
   end

   p_no_req_no_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_req |-> !pick_valid);

   p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> sel_elig);

   if (NUM_THREADS > 1) begin : g_multi_chk
      p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pick_valid |-> sel_qual);

      p_oldest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (pick_valid && (policy == POL_OLDEST || policy == POL_AGGRESSIVE)) |-> !older_seen);

      p_tie_low_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pick_valid && (policy == POL_OLDEST || policy == POL_AGGRESSIVE)) |-> !tie_lower);

      p_reserved_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (policy == 2'd3) |-> !pick_valid);
   end

endmodule

bind smt_commit_picker smt_commit_picker_chk #(
   .NUM_THREADS (NUM_THREADS),
   .SEQ_W       (SEQ_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .thr_status (thr_status),
   .head_ready (head_ready),
   .rob_empty  (rob_empty),
   .head_seq   (head_seq),
   .policy     (policy),
   .pick_req   (pick_req),
   .pick_valid (pick_valid),
   .pick_tid   (pick_tid)
);

// File: tb/smt_commit_picker_tb_top.sv
module smt_commit_picker_tb_top;

   localparam int NT = 4;
   localparam int SW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] st = '0;
   logic [3:0]  rdy = '0;
   logic [3:0]  emp = '1;
   logic [31:0] seq = '0;
   logic [1:0]  pol = 2'd1;
   logic        req = 1'b0;
   logic [2:0]  s1_st = 3'd0;
   logic        s1_rdy = 1'b0;
   logic        s1_emp = 1'b1;
   logic [7:0]  s1_seq = '0;

   logic        pv, pv1;
   logic [1:0]  ptid;
   logic        ptid1;

   int n_tests = 0;
   int n_fail  = 0;
   int ord [NT];
   bit done = 0;

   always #2 clk = ~clk;

   smt_commit_picker #(.NUM_THREADS(NT), .SEQ_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .thr_status(st), .head_ready(rdy),
      .rob_empty(emp), .head_seq(seq), .policy(pol), .pick_req(req),
      .pick_valid(pv), .pick_tid(ptid));

   smt_commit_picker #(.NUM_THREADS(1), .SEQ_W(SW)) dut1_i (
      .clk(clk), .rst_n(rst_n), .thr_status(s1_st), .head_ready(s1_rdy),
      .rob_empty(s1_emp), .head_seq(s1_seq), .policy(pol), .pick_req(req),
      .pick_valid(pv1), .pick_tid(ptid1));

   function automatic bit elig(input logic [2:0] s);
      return (s == 3'd0) || (s == 3'd1) || (s == 3'd4);
   endfunction

   function automatic void model(output bit v, output int t, output int pos);
      bit q [NT];
      int best;
      v = 0; t = 0; pos = 0; best = 0;
      for (int i = 0; i < NT; i++) q[i] = elig(st[3*i +: 3]) && rdy[i] && !emp[i];
      if (!req) return;
      if (pol == 2'd1) begin
         for (int p = 0; p < NT; p++)
            if (!v && q[ord[p]]) begin v = 1; t = ord[p]; pos = p; end
      end else if (pol != 2'd3) begin
         for (int i = 0; i < NT; i++)
            if (q[i] && (!v || int'(seq[8*i +: 8]) < best)) begin
               v = 1; t = i; best = int'(seq[8*i +: 8]);
            end
      end
   endfunction

   task automatic cyc(input string tag);
      bit ev; int et, epos, tmp;
      bit ev1;
      #1;
      model(ev, et, epos);
      n_tests++;
      if (pv !== ev || int'(ptid) != et) begin
         n_fail++;
         $display("FAIL %s: valid/tid actual %0b/%0d expected %0b/%0d", tag, pv, ptid, ev, et);
      end
      ev1 = req && elig(s1_st);
      n_tests++;
      if (pv1 !== ev1 || ptid1 !== 1'b0) begin
         n_fail++;
         $display("FAIL R10: single valid/tid actual %0b/%0d expected %0b/0", pv1, ptid1, ev1);
      end
      if (ev && pol == 2'd1) begin
         tmp = ord[epos];
         for (int p = epos; p < NT-1; p++) ord[p] = ord[p+1];
         ord[NT-1] = tmp;
      end
      @(negedge clk);
   endtask

   task automatic all_ready();
      st = {3'd1, 3'd1, 3'd1, 3'd1}; rdy = '1; emp = '0; seq = 32'h04030201;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NT; i++) ord[i] = i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: no request, no grant
      all_ready(); pol = 2'd1; req = 0;
      cyc("R11 idle");
      // R1 then R4: ascending start and rotation
      req = 1;
      cyc("R1 first grant after reset");
      repeat (4) cyc("R4 rotation");
      // R5: no request and other policy leave order
      req = 0; cyc("R5 no request");
      req = 1; pol = 2'd2; cyc("R5 oldest request");
      pol = 2'd1; cyc("R5 rotate after other policy");
      // R2: ineligible states
      st = {3'd4, 3'd7, 3'd3, 3'd2}; cyc("R2 only fetch-trap thread");
      st = {3'd5, 3'd6, 3'd3, 3'd0}; cyc("R2 only idle thread");
      // R3: ready and empty qualifiers
      all_ready(); rdy = 4'b0100; emp = 4'b0110; cyc("R3 ready but empty");
      rdy = 4'b1010; emp = 4'b0000; cyc("R3 partial ready");
      cyc("R3 partial ready again");
      // R6, R7, R8
      all_ready(); pol = 2'd2; seq = {8'd9, 8'd3, 8'd7, 8'd5}; cyc("R6 smallest seq");
      st[3*2 +: 3] = 3'd2; cyc("R6 oldest ineligible");
      all_ready(); seq = {8'd2, 8'd8, 8'd2, 8'd6}; cyc("R7 tie lower index");
      pol = 2'd0; cyc("R8 aggressive tie");
      seq = {8'd1, 8'd8, 8'd2, 8'd6}; cyc("R8 aggressive smallest");
      // R9: nothing qualifies
      pol = 2'd1; rdy = '0; cyc("R9 none ready rotate");
      pol = 2'd2; cyc("R9 none ready oldest");
      // R12: reserved policy
      all_ready(); pol = 2'd3; cyc("R12 reserved code");
      // R10: single-thread variant ignores readiness
      pol = 2'd1; s1_st = 3'd1; s1_rdy = 0; s1_emp = 1; cyc("R10 not ready still granted");
      s1_st = 3'd3; cyc("R10 trap wait blocks");
      s1_st = 3'd4; pol = 2'd3; cyc("R10 policy ignored");
      // random mix
      void'($urandom(32'd1234));
      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < NT; i++) st[3*i +: 3] = ($urandom % 3 == 0) ? 3'($urandom) : 3'd1;
         rdy = 4'($urandom); emp = 4'($urandom) & 4'($urandom);
         for (int i = 0; i < NT; i++) seq[8*i +: 8] = 8'($urandom % 6);
         pol = 2'($urandom); req = ($urandom % 4) != 0;
         s1_st = 3'($urandom); s1_rdy = 1'($urandom); s1_emp = 1'($urandom);
         cyc("R3 R4 R5 R6 R7 random");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule